// File: doc/BRIEF.md
# ADC Bring-up and Channel Readout Sequencer

This block is an SPI master for a four-input peak-detector converter. When reset is released it programs the converter without any outside help. The first frame turns on the internal reference and the temperature sensor. The next four frames set each input's span to 0 to 10 V. After that the block serves single reads.

A read request names an input channel, or asks for the die temperature. The block sends a manual-mode command that packs the channel number, the range code and the temperature-select bit into one byte. It then clocks one dummy frame to collect the 16-bit result, presents that result and pulses a valid strobe.

Every transfer is a 16-bit frame in SPI mode 0, sent most significant bit first, with chip select low for the whole frame. A parameter sets how long each half of the serial clock lasts. Its default of one system cycle gives a serial clock at half the system clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it, spi_cs_n is 1, spi_sclk is 0, busy is 1 and rsp_valid is 0.
- R2: The serial clock is 0 whenever spi_cs_n is 1. spi_mosi never changes while spi_sclk stays 1, so it changes only on falling edges or before the first rising edge.
- R3: Inside a frame, every high level and every low level of spi_sclk lasts exactly HALF_CYC system cycles.
- R4: Every frame has exactly 16 rising edges of spi_sclk while spi_cs_n is low, and shifts its word out MSB first.
- R5: spi_cs_n falls HALF_CYC cycles before the first rising edge and rises HALF_CYC cycles after the last falling edge. spi_cs_n is therefore low for 33*HALF_CYC cycles per frame.
- R6: After reset the block sends exactly five frames, in this order: 16'h0606, 16'h1050, 16'h1150, 16'h1250, 16'h1350 (address byte high, data byte low). busy stays 1 until the fifth frame has ended.
- R7: A channel read sends the command frame {8'h04, 1'b0, chan[1:0], 1'b0, 3'b101, 1'b0}. Channel 2, for example, gives 16'h044A.
- R8: A temperature read (req_temp=1) sends the command frame 16'h0401, whatever the value of req_chan.
- R9: After the command frame the block sends the frame 16'h0000. The 16 MISO bits sampled on the rising edges of that frame, MSB first, appear on rsp_data while rsp_valid is high for exactly one cycle.
- R10: req_start has no effect while busy is 1, during initialisation or during a read. No extra frame follows and no extra valid pulse appears.
- R11: busy rises in the cycle after an accepted req_start. rsp_valid is only high while busy is 0. spi_cs_n stays 1 while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Starts a read when busy is 0 |
| req_chan | input | 2 | Input channel to read |
| req_temp | input | 1 | Read the temperature sensor instead of a channel |
| rsp_data | output | 16 | Last conversion result |
| rsp_valid | output | 1 | One-cycle strobe marking a new rsp_data |
| busy | output | 1 | High during initialisation and during a read |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The assertions check the pin timing on every cycle: the serial clock stays low while chip select is high, MOSI does not move while the clock is high, every clock level lasts HALF_CYC cycles, and chip select has its setup and hold margins. They also check that each frame has exactly 16 rising edges, that valid is a single-cycle pulse given only while idle, and that an accepted start raises busy. The bench scenarios are the only place where the frame contents are shown: the order of the start-up words, the command byte for each channel and for the temperature sensor, and which frame's MISO bits end up on rsp_data. The same applies to start pulses that are ignored during initialisation and during a read.

// File: rtl/adc_seq_pkg.sv
// Package: shared constants and state types for the ADC sequencer.
// Assumes 8-bit register addresses and 8-bit register data on the converter.
package adc_seq_pkg;
    localparam int          FRAME_W      = 16;
    localparam int          NUM_CHAN     = 4;
    localparam int          CHAN_W       = $clog2(NUM_CHAN);
    localparam int          INIT_FRAMES  = 1 + NUM_CHAN;
    localparam int          INIT_IDX_W   = $clog2(INIT_FRAMES);

    localparam logic [7:0]  ADDR_CTRL    = 8'h06;
    localparam logic [7:0]  CTRL_SETTING = 8'b0000_0110;   // reference on, temp sensor on
    localparam logic [7:0]  ADDR_SPAN0   = 8'h10;          // first per-channel span register
    localparam logic [7:0]  SPAN_SETTING = 8'b0101_0000;   // 0..10 V
    localparam logic [7:0]  ADDR_MANUAL  = 8'h04;
    localparam logic [2:0]  SPAN_CODE    = 3'b101;         // 0..10 V inside the command byte

    typedef enum logic [1:0] {
        SQ_BOOT,
        SQ_READY,
        SQ_CMD,
        SQ_FETCH
    } seq_state_t;

    typedef enum logic [1:0] {
        FK_INIT,
        FK_CMD,
        FK_FETCH
    } frame_kind_t;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_HOLD,
        SH_GAP
    } shift_state_t;
endpackage

// File: rtl/spi_half_timer.sv
// Module: half-period timer for the serial clock.
// Fires tick once every HALF_CYC cycles while run is high; the count restarts
// from zero whenever run is low. Assumes HALF_CYC >= 1.
module spi_half_timer #(
    parameter int HALF_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count system cycles inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_frame_builder.sv
// Module: builds the 16-bit outgoing word for each frame kind.
// Start-up frames come from the step index (control first, then one span
// register per channel). Read commands pack channel, span code and the
// temperature-select bit. Fetch frames are all zeros. Purely combinational.
module adc_frame_builder
    import adc_seq_pkg::*;
(
    input  frame_kind_t            kind,
    input  logic [INIT_IDX_W-1:0]  init_idx,
    input  logic [CHAN_W-1:0]      chan,
    input  logic                   temp,
    output logic [FRAME_W-1:0]     word
);
    logic [7:0] span_addr;
    logic [7:0] cmd_byte;

    // Span register address for start-up steps 1..NUM_CHAN.
    assign span_addr = ADDR_SPAN0 + 8'(init_idx) - 8'd1;

    // Manual-mode byte: temperature select overrides channel and span fields.
    always_comb begin
        if (temp) begin
            cmd_byte = 8'b0000_0001;
        end else begin
            cmd_byte = {1'b0, chan, 1'b0, SPAN_CODE, 1'b0};
        end
    end

    // Select the frame word for the current kind.
    always_comb begin
        unique case (kind)
            FK_INIT: begin
                if (init_idx == '0) begin
                    word = {ADDR_CTRL, CTRL_SETTING};
                end else begin
                    word = {span_addr, SPAN_SETTING};
                end
            end
            FK_CMD:   word = {ADDR_MANUAL, cmd_byte};
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/spi_frame_shifter.sv
// Module: mode-0 SPI shifter for one fixed-length frame.
// On go (accepted only when idle) it drops chip select, then runs FRAME_W
// clock periods: MOSI changes while SCLK is low and MISO is captured as SCLK
// rises. Chip select rises one half period after the last falling edge and
// stays high one more half period before done pulses. Assumes go arrives
// only while the shifter is idle.
module spi_frame_shifter
    import adc_seq_pkg::*;
#(
    parameter int HALF_CYC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic [FRAME_W-1:0] rx_word,
    output logic               done
);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    shift_state_t       st;
    logic               tick;
    logic [BIT_W-1:0]   bit_idx;
    logic [FRAME_W-1:0] tx_sh;

    spi_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st != SH_IDLE),
        .tick  (tick)
    );

    // Frame state machine and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SH_IDLE;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            cs_n    <= 1'b1;
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_word <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                SH_IDLE: begin
                    if (go) begin
                        cs_n    <= 1'b0;
                        tx_sh   <= tx_word;
                        mosi    <= tx_word[FRAME_W-1];
                        bit_idx <= '0;
                        st      <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (tick) begin
                        sclk    <= 1'b1;
                        rx_word <= {rx_word[FRAME_W-2:0], miso};
                        st      <= SH_HIGH;
                    end
                end
                SH_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (bit_idx == LAST_BIT) begin
                            st <= SH_HOLD;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
                            mosi    <= tx_sh[FRAME_W-2];
                            st      <= SH_LOW;
                        end
                    end
                end
                SH_HOLD: begin
                    if (tick) begin
                        cs_n <= 1'b1;
                        st   <= SH_GAP;
                    end
                end
                default: begin
                    if (tick) begin
                        mosi <= 1'b0;
                        done <= 1'b1;
                        st   <= SH_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: converter bring-up and readout sequencer (top).
// After reset it sends the control frame and one span frame per channel, then
// accepts reads. A read is a manual-mode command frame followed by a zero
// frame whose MISO bits form the result. busy covers start-up and each read.
// req_start is only honoured while busy is low. Assumes the converter answers
// a command in the frame that follows it.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int HALF_CYC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_start,
    input  logic [1:0]         req_chan,
    input  logic               req_temp,
    output logic [15:0]        rsp_data,
    output logic               rsp_valid,
    output logic               busy,
    output logic               spi_sclk,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic               spi_cs_n
);
    localparam logic [INIT_IDX_W-1:0] LAST_INIT = INIT_IDX_W'(INIT_FRAMES - 1);

    seq_state_t            st;
    frame_kind_t           kind;
    logic                  launched;
    logic                  go;
    logic                  done;
    logic [INIT_IDX_W-1:0] init_idx;
    logic [CHAN_W-1:0]     chan_q;
    logic                  temp_q;
    logic [FRAME_W-1:0]    tx_word;
    logic [FRAME_W-1:0]    rx_word;

    assign busy = (st != SQ_READY);
    assign go   = busy && !launched;

    // Map the sequencer state to the kind of frame to send.
    always_comb begin
        unique case (st)
            SQ_BOOT: kind = FK_INIT;
            SQ_CMD:  kind = FK_CMD;
            default: kind = FK_FETCH;
        endcase
    end

    adc_frame_builder u_build (
        .kind     (kind),
        .init_idx (init_idx),
        .chan     (chan_q),
        .temp     (temp_q),
        .word     (tx_word)
    );

    spi_frame_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .tx_word (tx_word),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n),
        .rx_word (rx_word),
        .done    (done)
    );

    // Step through start-up frames, then command/fetch pairs per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_BOOT;
            launched  <= 1'b0;
            init_idx  <= '0;
            chan_q    <= '0;
            temp_q    <= 1'b0;
            rsp_data  <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (go) begin
                launched <= 1'b1;
            end
            unique case (st)
                SQ_BOOT: begin
                    if (done) begin
                        launched <= 1'b0;
                        if (init_idx == LAST_INIT) begin
                            st <= SQ_READY;
                        end else begin
                            init_idx <= init_idx + 1'b1;
                        end
                    end
                end
                SQ_READY: begin
                    if (req_start) begin
                        chan_q <= req_chan;
                        temp_q <= req_temp;
                        st     <= SQ_CMD;
                    end
                end
                SQ_CMD: begin
                    if (done) begin
                        launched <= 1'b0;
                        st       <= SQ_FETCH;
                    end
                end
                default: begin
                    if (done) begin
                        launched  <= 1'b0;
                        rsp_data  <= rx_word;
                        rsp_valid <= 1'b1;
                        st        <= SQ_READY;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_ctrl_checker.sv
// Module: protocol checker bound to adc_seq_ctrl.
// Measures serial-clock level lengths and rising edges per frame with its own
// counters and checks pin timing and handshake rules every cycle.
module adc_seq_ctrl_checker #(
    parameter int HALF_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic req_start,
    input logic rsp_valid,
    input logic busy,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n
);
    logic        prev_sclk;
    logic        prev_cs;
    logic [15:0] lvl_cnt;
    logic [5:0]  rise_cnt;

    // Track level lengths since the last clock change or chip-select fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sclk <= 1'b0;
            prev_cs   <= 1'b1;
            lvl_cnt   <= 16'd1;
            rise_cnt  <= '0;
        end else begin
            prev_sclk <= spi_sclk;
            prev_cs   <= spi_cs_n;
            if ((spi_sclk != prev_sclk) || (prev_cs && !spi_cs_n)) begin
                lvl_cnt <= 16'd1;
            end else if (lvl_cnt != 16'hFFFF) begin
                lvl_cnt <= lvl_cnt + 16'd1;
            end
            if (prev_cs && !spi_cs_n) begin
                rise_cnt <= '0;
            end else if (spi_sclk && !prev_sclk) begin
                rise_cnt <= rise_cnt + 6'd1;
            end
        end
    end

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && (spi_sclk != prev_sclk)) |-> (lvl_cnt == 16'(HALF_CYC)));

    assert_frame_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && !prev_cs) |-> (rise_cnt == 6'd16));

    assert_cs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && !prev_cs) |-> (lvl_cnt == 16'(HALF_CYC)));

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_valid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

    assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !busy) |=> busy);

    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_checker #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .rsp_valid (rsp_valid),
    .busy      (busy),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n)
);

// File: tb/adc_seq_ctrl_test.sv
// Bench: a behavioural converter model answers on MISO from a queue, a pin
// monitor decodes every frame, and expected frames and results come from the
// requirements. Pins are sampled on the falling clock edge.
module adc_seq_ctrl_test;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [1:0]  req_chan = 2'd0;
    logic        req_temp = 1'b0;
    logic [15:0] rsp_data;
    logic        rsp_valid;
    logic        busy;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;
    logic        spi_cs_n;

    int checks = 0;
    int errors = 0;
    logic [15:0] got_q[$];
    logic [15:0] resp_q[$];
    int valid_seen = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl #(.HALF_CYC(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_chan(req_chan),
        .req_temp(req_temp), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
        .busy(busy), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Pin monitor and converter model, compared on every clock.
    logic        m_prev_cs = 1'b1;
    logic        m_prev_sclk = 1'b0;
    logic        m_prev_mosi = 1'b0;
    logic [15:0] m_shift = '0;
    logic [15:0] s_shift = '0;
    int          m_bits = 0;
    int          m_low = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_prev_cs && !spi_cs_n) begin
                m_bits = 0;
                m_low = 0;
                s_shift = (resp_q.size() > 0) ? resp_q.pop_front() : 16'h5A3C;
                spi_miso = s_shift[15];
                s_shift = {s_shift[14:0], 1'b0};
            end
            if (!spi_cs_n) m_low++;
            if (spi_sclk && !m_prev_sclk) begin
                m_shift = {m_shift[14:0], spi_mosi};
                m_bits++;
            end
            if (!spi_sclk && m_prev_sclk && !spi_cs_n) begin
                spi_miso = s_shift[15];
                s_shift = {s_shift[14:0], 1'b0};
            end
            if (spi_sclk && m_prev_sclk)
                check(spi_mosi == m_prev_mosi, "R2 mosi moved while sclk high", spi_mosi, m_prev_mosi);
            if (spi_cs_n)
                check(!spi_sclk, "R2 sclk idle low", spi_sclk, 0);
            if (!m_prev_cs && spi_cs_n) begin
                got_q.push_back(m_shift);
                check(m_bits == 16, "R4 rising edges per frame", m_bits, 16);
                check(m_low == 33 * HALF, "R3/R5 cs low length", m_low, 33 * HALF);
            end
            if (rsp_valid) valid_seen++;
        end
        m_prev_cs = spi_cs_n;
        m_prev_sclk = spi_sclk;
        m_prev_mosi = spi_mosi;
    end

    task automatic wait_idle();
        int n;
        n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(!busy, "R6/R11 busy falls", busy, 0);
    endtask

    // One read: push junk then result into the model, start, check everything.
    task automatic do_read(input logic [1:0] ch, input logic tmp,
                           input logic [15:0] resp, input logic [15:0] exp_cmd,
                           input bit poke);
        int n;
        int v0;
        got_q.delete();
        resp_q.delete();
        resp_q.push_back(~resp);
        resp_q.push_back(resp);
        v0 = valid_seen;
        req_chan = ch;
        req_temp = tmp;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        check(busy, "R11 busy after start", busy, 1);
        if (poke) begin
            repeat (50) @(negedge clk);
            req_chan = ~ch;
            req_temp = ~tmp;
            req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
        end
        n = 0;
        while (!rsp_valid && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(rsp_valid, "R9 valid arrives", rsp_valid, 1);
        check(rsp_data == resp, "R9 result from fetch frame", rsp_data, resp);
        check(!busy, "R11 idle while valid", busy, 0);
        @(negedge clk);
        check(!rsp_valid, "R9 valid one cycle", rsp_valid, 0);
        repeat (40) @(negedge clk);
        check(got_q.size() == 2, "R10 frames per read", got_q.size(), 2);
        if (got_q.size() == 2) begin
            check(got_q[0] == exp_cmd, tmp ? "R8 temp command" : "R7 channel command", got_q[0], exp_cmd);
            check(got_q[1] == 16'h0000, "R9 fetch frame zero", got_q[1], 0);
        end
        check(valid_seen - v0 == 1, "R10 single valid per read", valid_seen - v0, 1);
        check(spi_cs_n, "R11 cs high while idle", spi_cs_n, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] init_exp[5];
        init_exp = '{16'h0606, 16'h1050, 16'h1150, 16'h1250, 16'h1350};
        repeat (3) @(negedge clk);
        check(spi_cs_n && !spi_sclk && busy && !rsp_valid, "R1 reset state",
              {spi_cs_n, spi_sclk, busy, rsp_valid}, 4'b1010);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy && !rsp_valid, "R1 busy after reset", {busy, rsp_valid}, 2'b10);
        // R10: start pulses during initialisation are ignored.
        repeat (30) @(negedge clk);
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        repeat (150) @(negedge clk);
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_idle();
        repeat (40) @(negedge clk);
        check(got_q.size() == 5, "R6/R10 start-up frame count", got_q.size(), 5);
        for (int i = 0; i < 5; i++) begin
            if (i < got_q.size())
                check(got_q[i] == init_exp[i], "R6 start-up frame", got_q[i], init_exp[i]);
        end
        check(valid_seen == 0, "R10 no valid during start-up", valid_seen, 0);
        do_read(2'd0, 1'b0, 16'h8001, 16'h040A, 1'b0);
        do_read(2'd1, 1'b0, 16'h1234, 16'h042A, 1'b0);
        do_read(2'd2, 1'b0, 16'hFFFF, 16'h044A, 1'b0);
        do_read(2'd3, 1'b0, 16'h0000, 16'h046A, 1'b0);
        do_read(2'd3, 1'b1, 16'hBEEF, 16'h0401, 1'b0);
        do_read(2'd1, 1'b0, 16'hC3A5, 16'h042A, 1'b1);
        do_read(2'd0, 1'b1, 16'h7E01, 16'h0401, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule